// File: doc/BRIEF.md
# Thirteen-Level Staircase Gate Pattern Generator

This block drives the nine power switches of a single-phase inverter that builds a thirteen-step staircase from four DC sources weighted 1:1:2:2. A free-running phase accumulator covers one fundamental period. The phase is folded into the first quarter, then compared against six programmable step angles, which gives a signed output level from -6 to +6. A small decoder turns each level into the switch pattern that the power stage needs.

The angle registers are sampled into shadow copies only when a new period begins, so software may rewrite them at any time. The bench shows the same wave shape in every period. The two shorted-output states are used in turn, so that the stress from zero crossings is shared between the two switch pairs. The level and the gate word both come from registers that load on the same edge.

Top module: `staircase_gate_gen`

## Requirements
- R1: While `rst` is high or `enable` is low, `gates`, `level` and `cycleStart` read 0 after the next clock edge, and the phase restarts from 0.
- R2: With `enable` high, the internal phase starts at 0 and grows by `phaseInc` modulo 2^16 on every edge (2^16 = one period). The outputs after edge n reflect the phase as it was before that edge, which is (n-1)*phaseInc.
- R3: In the first quarter (phase below 16384), the level magnitude is the number of shadow angles less than or equal to the phase.
- R4: In the second quarter (phase bit 14 set, bit 15 clear), the magnitude is computed as in R3 on the folded value 32768 - phase[14:0].
- R5: When phase bit 15 is set, the level is the negative of the level for phase - 32768.
- R6: `gates[8]` is S1 and `gates[0]` is S9. Levels +1..+6 give 100011001, 010011001, 101001001, 011001001, 100101001 and 010101001.
- R7: Level -k keeps the S1..S5 bits of level +k and sets S6..S9 to 0110. For example, -1 gives 100010110.
- R8: Level 0 gives 000000011 when the last nonzero level was positive. It gives 000001100 when the last nonzero level was negative, and also when none has occurred since the block was enabled.
- R9: Whenever the level is nonzero, exactly four gate bits are 1.
- R10: `cycleStart` is high for the one cycle that follows an edge at which the phase wraps. The shadow angles load from `angles` at that edge, or at any edge while `enable` is low. Changes made between wraps have no effect until then.
- R11: `level` and `gates` are registered and change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| enable | input | 1 | Run the generator |
| phaseInc | input | 16 | Phase step per clock |
| angles | input | 6x16 | Step angles, ascending, same scale as the phase |
| gates | output | 9 | Switch drive, S1 in bit 8 to S9 in bit 0 |
| level | output | 4 | Signed output level, -6..+6 |
| cycleStart | output | 1 | Pulse at the start of each period |

## Verification
Two events can fall in the same cycle: the period wrap, which reloads the shadow angles and raises `cycleStart`, and the return to zero at the end of the negative half-wave, where the zero-state choice depends on the polarity history. The bench rewrites all angles in the middle of a period and runs across the wrap. There it checks that the old angles still govern the last samples before the wrap, that `cycleStart` rises on the wrap, and that the first sample after the wrap already uses the new angles while the zero state is still the negative-history one. A cycle-by-cycle sweep against a phase model also lands the wrap on zero-level samples, for several step sizes.

// File: rtl/sgg_pkg.sv
package sgg_pkg;
  localparam int PHASE_W    = 16;
  localparam int NUM_ANGLES = 6;
  localparam int GATE_W     = 9;
  localparam int LEVEL_W    = 4;

  typedef struct packed {
    logic run;
    logic loadAngles;
  } ctrl_t;
endpackage

// File: rtl/sgg_phase_ctrl.sv
module sgg_phase_ctrl
  import sgg_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [PW-1:0] phaseInc,
  output logic [PW-1:0] phase,
  output ctrl_t         ctl,
  output logic          cycleStart
);
  logic [PW:0] phaseSum;

  assign phaseSum       = {1'b0, phase} + {1'b0, phaseInc};
  assign ctl.run        = enable;
  assign ctl.loadAngles = !enable || phaseSum[PW];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase      <= '0;
      cycleStart <= 1'b0;
    end else if (!enable) begin
      phase      <= '0;
      cycleStart <= 1'b0;
    end else begin
      phase      <= phaseSum[PW-1:0];
      cycleStart <= phaseSum[PW];
    end
  end

  // R1: idle restarts the phase and keeps the strobe low
  assert_idle_restart_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (phase == '0 && !cycleStart));

  // R10: after a wrap the phase sits below the step that caused it
  assert_wrap_small_R10: assert property (@(posedge clk) disable iff (rst)
    (enable && cycleStart) |-> (phase < $past(phaseInc)));
endmodule

// File: rtl/sgg_level_path.sv
module sgg_level_path
  import sgg_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int NA = NUM_ANGLES,
  parameter int GW = GATE_W,
  parameter int LW = LEVEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrl_t                 ctl,
  input  logic [PW-1:0]         phase,
  input  logic [NA-1:0][PW-1:0] angles,
  output logic signed [LW-1:0]  level,
  output logic [GW-1:0]         gates
);
  localparam logic [PW-1:0] HALF_TURN = PW'(1) << (PW - 1);
  localparam logic [GW-1:0] ZERO_LOW  = 9'b000001100;
  localparam logic [GW-1:0] ZERO_HIGH = 9'b000000011;

  logic [NA-1:0][PW-1:0] shadow;
  logic [PW-1:0]         foldPh;
  logic [NA-1:0]         passed;
  logic [LW-1:0]         magn;
  logic                  negHalf;
  logic                  lastPos;
  logic signed [LW-1:0]  levelNext;
  logic [GW-1:0]         gatesNext;
  logic [1:0]            sPair;
  logic [2:0]            sMid;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) shadow <= '0;
    else if (ctl.loadAngles) shadow <= angles;
  end

  // fold the second quarter back onto the first
  assign foldPh = phase[PW-2] ? (HALF_TURN - {1'b0, phase[PW-2:0]})
                              : {1'b0, phase[PW-2:0]};

  for (genvar i = 0; i < NA; i++) begin : g_cmp
    assign passed[i] = foldPh >= shadow[i];
  end

  assign magn      = LW'($countones(passed));
  assign negHalf   = phase[PW-1] && (magn != '0);
  assign levelNext = negHalf ? -$signed(magn) : $signed(magn);

  always_comb begin
    sPair = magn[0] ? 2'b10 : 2'b01;
    case (magn)
      4'd1, 4'd2: sMid = 3'b001;
      4'd3, 4'd4: sMid = 3'b100;
      default:    sMid = 3'b010;
    endcase
    if (magn == '0) gatesNext = lastPos ? ZERO_HIGH : ZERO_LOW;
    else            gatesNext = {sPair, sMid, negHalf ? 4'b0110 : 4'b1001};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      level   <= '0;
      gates   <= '0;
      lastPos <= 1'b0;
    end else if (!ctl.run) begin
      level   <= '0;
      gates   <= '0;
      lastPos <= 1'b0;
    end else begin
      level <= levelNext;
      gates <= gatesNext;
      if (magn != '0) lastPos <= !negHalf;
    end
  end

  // R9: four switches on for any nonzero level
  assert_four_on_R9: assert property (@(posedge clk) disable iff (rst)
    (level != 0) |-> ($countones(gates) == 4));

  // R1: idle drives nothing
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !ctl.run |=> (gates == '0 && level == 0));

  // R8: a zero level uses one of the two shorting states or is idle
  assert_zero_state_R8: assert property (@(posedge clk) disable iff (rst)
    (level == 0) |-> (gates == ZERO_LOW || gates == ZERO_HIGH || gates == '0));

  // R8: leaving a positive level into zero picks the lower pair
  assert_zero_after_pos_R8: assert property (@(posedge clk) disable iff (rst)
    (level > 0 && ctl.run) |=> (level != 0 || gates == ZERO_HIGH || gates == '0));

  // R10: shadow angles only move on a load strobe
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadAngles |=> $stable(shadow));
endmodule

// File: rtl/staircase_gate_gen.sv
module staircase_gate_gen
  import sgg_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  enable,
  input  logic [PHASE_W-1:0]                    phaseInc,
  input  logic [NUM_ANGLES-1:0][PHASE_W-1:0]    angles,
  output logic [GATE_W-1:0]                     gates,
  output logic signed [LEVEL_W-1:0]             level,
  output logic                                  cycleStart
);
  logic [PHASE_W-1:0] phase;
  ctrl_t              ctl;

  sgg_phase_ctrl #(.PW(PHASE_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .phaseInc(phaseInc),
    .phase(phase), .ctl(ctl), .cycleStart(cycleStart)
  );

  sgg_level_path #(.PW(PHASE_W), .NA(NUM_ANGLES), .GW(GATE_W), .LW(LEVEL_W)) u_path (
    .clk(clk), .rst(rst), .ctl(ctl), .phase(phase), .angles(angles),
    .level(level), .gates(gates)
  );
endmodule

// File: tb/staircase_gate_gen_bench.sv
module staircase_gate_gen_bench;
  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable = 1'b0;
  logic [15:0]      phaseInc = 16'd0;
  logic [5:0][15:0] angles;
  logic [8:0]       gates;
  logic signed [3:0] level;
  logic             cycleStart;

  int errors = 0;
  int checks = 0;
  bit lastPosM = 1'b0;

  localparam int DEF_ANG [6] = '{870, 2636, 4482, 6497, 8846, 12095};
  localparam logic [8:0] POS_PAT [6] = '{9'b100011001, 9'b010011001, 9'b101001001,
                                         9'b011001001, 9'b100101001, 9'b010101001};
  // stimulus table: phaseInc 1000, edges after enable, expected level, zero after positive
  localparam int NV = 14;
  localparam int V_EDGES [NV] = '{1, 2, 4, 6, 8, 10, 14, 18, 28, 33, 35, 45, 50, 66};
  localparam int V_LEVEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 6, 3, 0, -1, -5, -6, 0};
  localparam int V_ZPOS  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0};

  staircase_gate_gen u_staircase_gate_gen (
    .clk(clk), .rst(rst), .enable(enable), .phaseInc(phaseInc), .angles(angles),
    .gates(gates), .level(level), .cycleStart(cycleStart)
  );

  always #4 clk = ~clk;

  function automatic int lvlOf(int p);
    int q, f, m;
    q = p & 32'h7FFF;
    f = (q >= 16384) ? (32768 - q) : q;
    m = 0;
    for (int i = 0; i < 6; i++) if (f >= DEF_ANG[i]) m++;
    return ((p & 32'h8000) != 0) ? -m : m;
  endfunction

  function automatic logic [8:0] gatesOf(int lv, bit zpos);
    if (lv == 0) return zpos ? 9'b000000011 : 9'b000001100;
    if (lv > 0) return POS_PAT[lv-1];
    return {POS_PAT[-lv-1][8:4], 4'b0110};
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic setDefaults();
    for (int i = 0; i < 6; i++) angles[i] = 16'(DEF_ANG[i]);
  endtask

  task automatic idle(int n);
    enable = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic sweep(int inc, int cycles);
    int ph;
    int lv;
    idle(2);
    phaseInc = 16'(inc);
    enable = 1'b1;
    ph = 0;
    lastPosM = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk); #2;
      lv = lvlOf(ph);
      check("R2/R3/R4/R5 level", int'(level), lv);
      check("R6/R7/R8 gates", int'(gates), int'(gatesOf(lv, lastPosM)));
      check("R10 cycleStart", int'(cycleStart), (ph + inc >= 65536) ? 1 : 0);
      if (lv != 0) begin
        check("R9 four on", $countones(gates), 4);
        lastPosM = (lv > 0);
      end
      ph = (ph + inc) & 32'hFFFF;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int done;
    setDefaults();
    // R1: reset state
    repeat (3) @(posedge clk); #2;
    check("R1 reset gates", int'(gates), 0);
    check("R1 reset level", int'(level), 0);
    check("R1 reset cycleStart", int'(cycleStart), 0);
    rst = 1'b0;
    idle(2);
    check("R1 disabled gates", int'(gates), 0);

    // table walk, R11: level and gates sampled together
    phaseInc = 16'd1000;
    enable = 1'b1;
    done = 0;
    for (int i = 0; i < NV; i++) begin
      repeat (V_EDGES[i] - done) @(posedge clk);
      #2;
      done = V_EDGES[i];
      check("R3/R4/R5 table level", int'(level), V_LEVEL[i]);
      check("R6/R7/R8 R11 table gates", int'(gates), int'(gatesOf(V_LEVEL[i], V_ZPOS[i] != 0)));
    end

    // R1: drop enable mid-run
    idle(1);
    check("R1 stop gates", int'(gates), 0);
    check("R1 stop level", int'(level), 0);

    // R10: angle change mid-period is held until the wrap
    phaseInc = 16'd1000;
    enable = 1'b1;
    repeat (5) @(posedge clk); #2;
    for (int i = 0; i < 6; i++) angles[i] = 16'h7FFF;
    repeat (5) @(posedge clk); #2;
    check("R10 old angles kept", int'(level), 5);
    repeat (55) @(posedge clk); #2;
    check("R10 no strobe before wrap", int'(cycleStart), 0);
    @(posedge clk); #2;
    check("R10 strobe at wrap", int'(cycleStart), 1);
    check("R8 zero after negative", int'(gates), 9'b000001100);
    @(posedge clk); #2;
    check("R10 strobe one cycle", int'(cycleStart), 0);
    @(posedge clk); #2;
    check("R10 new angles used", int'(level), 0);
    check("R10 new angles gates", int'(gates), 9'b000001100);
    setDefaults();

    // continuous sweeps with several step sizes
    sweep(313, 700);
    sweep(16384, 12);
    sweep(4099, 60);

    idle(1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule